// File: doc/BRIEF.md
# IPv4 Longest-Prefix Forwarding Stage

This block is a single match-action stage of a packet pipeline. Each cycle it may accept one parsed packet: a flag that says the IPv4 header is present, the IPv4 destination address and TTL, both Ethernet MAC addresses, and two metadata fields, the selected output port and a drop flag. When the IPv4 header is present, the stage compares the destination address against every valid entry of a table in parallel. Each entry holds a key, a per-bit mask and a prefix length. Among the entries that match, it picks the one with the longest prefix and applies that entry's action to the headers and metadata.

A control-plane write port fills the table one entry at a time. Each write carries an index, a valid bit, the key, the mask, the prefix length, an action code and the action parameters: an output port and a MAC address. A forward action steers the packet to the entry's port. It moves the old destination MAC into the source field, loads the entry's MAC as the new destination and lowers the TTL by one. Drop and no-action entries are also supported. A lookup with no match drops the packet. A packet without a valid IPv4 header passes through unchanged. Results leave the stage three cycles after they enter, fully pipelined and in order.

Top module: `lpm_fwd_stage`

## Requirements
- R1: After synchronous reset `out_vld` is 0 and every table entry is invalid, so an IPv4 packet sent before any table write misses and is dropped.
- R2: Each cycle with `in_vld` high gives exactly one cycle with `out_vld` high, three clock edges after the input is sampled. Packets may arrive back to back, and results leave in arrival order.
- R3: An entry matches when it is valid and `((dst ^ key) & mask) == 0`. A mask bit of 0 excludes that address bit from the compare, and the zero bits need not be contiguous.
- R4: When several entries match, the entry with the largest prefix length field wins. Among entries with equal prefix length, the one at the lowest index wins.
- R5: A valid IPv4 packet that matches no entry leaves with `out_drop`=1 and `out_hit`=0. Its headers and output port are unchanged.
- R6: Action code 1 (forward) with an incoming TTL of 2 or more does four things: it sets the output port to the entry's port, moves the old destination MAC into the source MAC, sets the destination MAC to the entry's MAC, and lowers the TTL by one. `out_drop` keeps the incoming drop flag.
- R7: A forward hit whose incoming TTL is 0 or 1 sets `out_drop`=1 and leaves the TTL, both MACs and the output port unchanged.
- R8: Action codes 2 and 3 (drop) set `out_drop`=1 and leave the headers and output port unchanged.
- R9: Action code 0 (no-action) leaves all headers and metadata unchanged, with `out_hit`=1.
- R10: When `in_ip_valid` is 0, no lookup takes place. Every field, including the drop flag and the output port, passes through unchanged, with `out_hit`=0.
- R11: A table write stores the entry at `cfg_idx` at that clock edge. Writing with `cfg_valid`=0 removes the entry. Packets sampled at any later edge see the new contents.
- R12: An incoming `in_drop`=1 always gives `out_drop`=1, whatever the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_valid | input | 1 | Valid bit of the written entry |
| cfg_key | input | 32 | Match key |
| cfg_mask | input | 32 | Per-bit compare mask (1 = compare) |
| cfg_plen | input | PLEN_W | Prefix length used for priority |
| cfg_act | input | 2 | Action code: 0 none, 1 forward, 2 or 3 drop |
| cfg_port | input | PORT_W | Forward output port parameter |
| cfg_mac | input | 48 | Forward destination MAC parameter |
| in_vld | input | 1 | Packet present this cycle |
| in_ip_valid | input | 1 | IPv4 header parsed and valid |
| in_dst_ip | input | 32 | IPv4 destination address |
| in_ttl | input | 8 | IPv4 TTL |
| in_eth_dst | input | 48 | Ethernet destination MAC |
| in_eth_src | input | 48 | Ethernet source MAC |
| in_egress | input | PORT_W | Incoming output-port metadata |
| in_drop | input | 1 | Incoming drop flag |
| out_vld | output | 1 | Result present this cycle |
| out_hit | output | 1 | A valid entry matched |
| out_ip_valid | output | 1 | IPv4 header valid flag |
| out_dst_ip | output | 32 | IPv4 destination address |
| out_ttl | output | 8 | IPv4 TTL after the action |
| out_eth_dst | output | 48 | Ethernet destination MAC after the action |
| out_eth_src | output | 48 | Ethernet source MAC after the action |
| out_egress | output | PORT_W | Output-port metadata after the action |
| out_drop | output | 1 | Drop flag after the action |

## Verification
On every cycle the assertions check properties that need no table state. They check the three-cycle valid latency and the exact pass-through of non-IPv4 packets. They check that an incoming drop flag always survives and that a miss always drops. They also check that the TTL either stays as it was or drops by exactly one, on a hit, and never moves from 0 or 1. Everything that depends on the table contents can only be shown by the bench scenarios, because the result depends on which entry was written where. This covers the masked compare with non-contiguous masks, the longest-prefix choice and its tie-break by index, the meaning of each action code, the MAC rewrite, and removing an entry.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int IP_W  = 32;
  localparam int MAC_W = 48;
  localparam int TTL_W = 8;

  typedef enum logic [1:0] {
    ACT_NOP      = 2'd0,
    ACT_FWD      = 2'd1,
    ACT_DROP     = 2'd2,
    ACT_DROP_ALT = 2'd3
  } act_e;

  typedef struct packed {
    logic             ip_valid;
    logic [IP_W-1:0]  dst;
    logic [TTL_W-1:0] ttl;
    logic [MAC_W-1:0] eth_dst;
    logic [MAC_W-1:0] eth_src;
  } hdr_t;
endpackage

// File: rtl/lpm_entry_cmp.sv
module lpm_entry_cmp #(
  parameter int KEY_W = 32
) (
  input  logic             ent_valid,
  input  logic [KEY_W-1:0] ent_key,
  input  logic [KEY_W-1:0] ent_mask,
  input  logic [KEY_W-1:0] probe,
  output logic             hit
);
  logic [KEY_W-1:0] diff;

  always_comb begin
    diff = (probe ^ ent_key) & ent_mask;
    hit  = ent_valid && (diff == '0);
  end
endmodule

// File: rtl/lpm_prio_select.sv
module lpm_prio_select #(
  parameter int N      = 16,
  parameter int PLEN_W = 6,
  parameter int IDX_W  = 4
) (
  input  logic [N-1:0]      hits,
  input  logic [PLEN_W-1:0] plen [N],
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  logic [PLEN_W-1:0] best_len;

  // Strict greater-than keeps the lowest index on equal lengths.
  always_comb begin
    found    = 1'b0;
    idx      = '0;
    best_len = '0;
    for (int i = 0; i < N; i++) begin
      if (hits[i] && (!found || (plen[i] > best_len))) begin
        found    = 1'b1;
        idx      = IDX_W'(i);
        best_len = plen[i];
      end
    end
  end
endmodule

// File: rtl/lpm_action_ram.sv
module lpm_action_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 59
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lpm_rewrite.sv
module lpm_rewrite
  import lpm_pkg::*;
#(
  parameter int PORT_W = 9
) (
  input  hdr_t              h_in,
  input  logic [PORT_W-1:0] egress_in,
  input  logic              drop_in,
  input  logic              found,
  input  act_e              act,
  input  logic [PORT_W-1:0] act_port,
  input  logic [MAC_W-1:0]  act_mac,
  output hdr_t              h_out,
  output logic [PORT_W-1:0] egress_out,
  output logic              drop_out,
  output logic              hit_out
);
  always_comb begin
    h_out      = h_in;
    egress_out = egress_in;
    drop_out   = drop_in;
    hit_out    = 1'b0;
    if (h_in.ip_valid) begin
      if (!found) begin
        drop_out = 1'b1;
      end else begin
        hit_out = 1'b1;
        unique case (act)
          ACT_NOP: ;
          ACT_FWD: begin
            if (h_in.ttl <= TTL_W'(1)) begin
              drop_out = 1'b1;
            end else begin
              egress_out    = act_port;
              h_out.eth_src = h_in.eth_dst;
              h_out.eth_dst = act_mac;
              h_out.ttl     = h_in.ttl - TTL_W'(1);
            end
          end
          ACT_DROP, ACT_DROP_ALT: drop_out = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/lpm_fwd_stage.sv
module lpm_fwd_stage
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PORT_W  = 9,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int PLEN_W  = $clog2(IP_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [31:0]       cfg_key,
  input  logic [31:0]       cfg_mask,
  input  logic [PLEN_W-1:0] cfg_plen,
  input  logic [1:0]        cfg_act,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [47:0]       cfg_mac,
  input  logic              in_vld,
  input  logic              in_ip_valid,
  input  logic [31:0]       in_dst_ip,
  input  logic [7:0]        in_ttl,
  input  logic [47:0]       in_eth_dst,
  input  logic [47:0]       in_eth_src,
  input  logic [PORT_W-1:0] in_egress,
  input  logic              in_drop,
  output logic              out_vld,
  output logic              out_hit,
  output logic              out_ip_valid,
  output logic [31:0]       out_dst_ip,
  output logic [7:0]        out_ttl,
  output logic [47:0]       out_eth_dst,
  output logic [47:0]       out_eth_src,
  output logic [PORT_W-1:0] out_egress,
  output logic              out_drop
);
  localparam int ACT_W = 2;
  localparam int RAM_W = ACT_W + PORT_W + MAC_W;

  // Match side: registers, compared in parallel
  logic [ENTRIES-1:0] tbl_valid;
  logic [IP_W-1:0]    tbl_key  [ENTRIES];
  logic [IP_W-1:0]    tbl_mask [ENTRIES];
  logic [PLEN_W-1:0]  tbl_plen [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  hdr_t in_hdr;
  always_comb begin
    in_hdr.ip_valid = in_ip_valid;
    in_hdr.dst      = in_dst_ip;
    in_hdr.ttl      = in_ttl;
    in_hdr.eth_dst  = in_eth_dst;
    in_hdr.eth_src  = in_eth_src;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl_valid[e] <= 1'b0;
      end else if (cfg_we && (cfg_idx == IDX_W'(e))) begin
        tbl_valid[e] <= cfg_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (cfg_we && (cfg_idx == IDX_W'(e))) begin
        tbl_key[e]  <= cfg_key;
        tbl_mask[e] <= cfg_mask;
        tbl_plen[e] <= cfg_plen;
      end
    end

    lpm_entry_cmp #(.KEY_W(IP_W)) u_cmp (
      .ent_valid (tbl_valid[e]),
      .ent_key   (tbl_key[e]),
      .ent_mask  (tbl_mask[e]),
      .probe     (in_dst_ip),
      .hit       (hit_vec[e])
    );
  end

  logic             sel_found;
  logic [IDX_W-1:0] sel_idx;

  lpm_prio_select #(.N(ENTRIES), .PLEN_W(PLEN_W), .IDX_W(IDX_W)) u_sel (
    .hits  (hit_vec),
    .plen  (tbl_plen),
    .found (sel_found),
    .idx   (sel_idx)
  );

  // Stage 1: match result registered
  logic              s1_vld, s1_found, s1_drop;
  logic [IDX_W-1:0]  s1_idx;
  hdr_t              s1_hdr;
  logic [PORT_W-1:0] s1_egress;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= in_vld;
    end
    s1_found  <= sel_found && in_ip_valid;
    s1_idx    <= sel_idx;
    s1_hdr    <= in_hdr;
    s1_egress <= in_egress;
    s1_drop   <= in_drop;
  end

  // Stage 2: action data read from inferred RAM
  logic [RAM_W-1:0] ram_wdata, ram_rdata;
  assign ram_wdata = {cfg_act, cfg_port, cfg_mac};

  lpm_action_ram #(.DEPTH(ENTRIES), .AW(IDX_W), .DW(RAM_W)) u_act_ram (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_idx),
    .wdata (ram_wdata),
    .raddr (s1_idx),
    .rdata (ram_rdata)
  );

  logic              s2_vld, s2_found, s2_drop;
  hdr_t              s2_hdr;
  logic [PORT_W-1:0] s2_egress;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
    end
    s2_found  <= s1_found;
    s2_hdr    <= s1_hdr;
    s2_egress <= s1_egress;
    s2_drop   <= s1_drop;
  end

  act_e              rd_act;
  logic [PORT_W-1:0] rd_port;
  logic [MAC_W-1:0]  rd_mac;
  assign rd_act  = act_e'(ram_rdata[RAM_W-1 -: ACT_W]);
  assign rd_port = ram_rdata[MAC_W +: PORT_W];
  assign rd_mac  = ram_rdata[MAC_W-1:0];

  hdr_t              rw_hdr;
  logic [PORT_W-1:0] rw_egress;
  logic              rw_drop, rw_hit;

  lpm_rewrite #(.PORT_W(PORT_W)) u_rw (
    .h_in       (s2_hdr),
    .egress_in  (s2_egress),
    .drop_in    (s2_drop),
    .found      (s2_found),
    .act        (rd_act),
    .act_port   (rd_port),
    .act_mac    (rd_mac),
    .h_out      (rw_hdr),
    .egress_out (rw_egress),
    .drop_out   (rw_drop),
    .hit_out    (rw_hit)
  );

  // Stage 3: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld      <= 1'b0;
      out_hit      <= 1'b0;
      out_ip_valid <= 1'b0;
      out_dst_ip   <= '0;
      out_ttl      <= '0;
      out_eth_dst  <= '0;
      out_eth_src  <= '0;
      out_egress   <= '0;
      out_drop     <= 1'b0;
    end else begin
      out_vld      <= s2_vld;
      out_hit      <= rw_hit;
      out_ip_valid <= rw_hdr.ip_valid;
      out_dst_ip   <= rw_hdr.dst;
      out_ttl      <= rw_hdr.ttl;
      out_eth_dst  <= rw_hdr.eth_dst;
      out_eth_src  <= rw_hdr.eth_src;
      out_egress   <= rw_egress;
      out_drop     <= rw_drop;
    end
  end
endmodule

// File: rtl/lpm_fwd_stage_chk.sv
module lpm_fwd_stage_chk #(
  parameter int PORT_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic              in_ip_valid,
  input logic [7:0]        in_ttl,
  input logic [PORT_W-1:0] in_egress,
  input logic              in_drop,
  input logic              out_vld,
  input logic              out_hit,
  input logic              out_ip_valid,
  input logic [7:0]        out_ttl,
  input logic [PORT_W-1:0] out_egress,
  input logic              out_drop
);
  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_vld && !out_hit && !out_drop));

  // R2
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    warm |-> (out_vld == $past(in_vld, 3)));

  // R10
  a_r10_bypass: assert property (@(posedge clk) disable iff (rst)
    (warm && out_vld && !out_ip_valid) |->
      (!out_hit && out_ttl == $past(in_ttl, 3) &&
       out_egress == $past(in_egress, 3) && out_drop == $past(in_drop, 3)));

  // R12
  a_r12_drop_kept: assert property (@(posedge clk) disable iff (rst)
    (warm && out_vld && $past(in_drop, 3)) |-> out_drop);

  // R5
  a_r5_miss_drops: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_ip_valid && !out_hit) |-> out_drop);

  // R7
  a_r7_ttl_floor: assert property (@(posedge clk) disable iff (rst)
    (warm && out_vld && $past(in_ttl, 3) <= 8'd1) |-> (out_ttl == $past(in_ttl, 3)));

  // R6
  a_r6_ttl_step: assert property (@(posedge clk) disable iff (rst)
    (warm && out_vld && out_ttl != $past(in_ttl, 3)) |->
      (out_hit && out_ttl == 8'($past(in_ttl, 3) - 8'd1)));
endmodule

bind lpm_fwd_stage lpm_fwd_stage_chk #(.PORT_W(PORT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_vld       (in_vld),
  .in_ip_valid  (in_ip_valid),
  .in_ttl       (in_ttl),
  .in_egress    (in_egress),
  .in_drop      (in_drop),
  .out_vld      (out_vld),
  .out_hit      (out_hit),
  .out_ip_valid (out_ip_valid),
  .out_ttl      (out_ttl),
  .out_egress   (out_egress),
  .out_drop     (out_drop)
);

// File: tb/sim_lpm_fwd_stage.sv
module sim_lpm_fwd_stage;
  localparam int N  = 16;
  localparam int PW = 9;
  localparam int IW = 4;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [31:0]   cfg_key = '0, cfg_mask = '0;
  logic [LW-1:0] cfg_plen = '0;
  logic [1:0]    cfg_act = '0;
  logic [PW-1:0] cfg_port = '0;
  logic [47:0]   cfg_mac = '0;
  logic          in_vld = 1'b0, in_ip_valid = 1'b0, in_drop = 1'b0;
  logic [31:0]   in_dst_ip = '0;
  logic [7:0]    in_ttl = '0;
  logic [47:0]   in_eth_dst = '0, in_eth_src = '0;
  logic [PW-1:0] in_egress = '0;
  logic          out_vld, out_hit, out_ip_valid, out_drop;
  logic [31:0]   out_dst_ip;
  logic [7:0]    out_ttl;
  logic [47:0]   out_eth_dst, out_eth_src;
  logic [PW-1:0] out_egress;

  always #10 clk = ~clk;

  lpm_fwd_stage #(.ENTRIES(N), .PORT_W(PW)) u0 (.*);

  typedef struct {
    int          due;
    string       tag;
    logic        hit, ipv, drop;
    logic [31:0] dst;
    logic [7:0]  ttl;
    logic [47:0] edst, esrc;
    logic [PW-1:0] eg;
  } exp_t;

  exp_t   q[$];
  int     tests = 0, fails = 0, pcyc = 0, wd = 0;
  string  cur_tag = "";

  // Behavioural table
  bit          m_v [N];
  logic [31:0] m_key [N], m_mask [N];
  int          m_plen [N];
  int          m_act [N];
  logic [PW-1:0] m_port [N];
  logic [47:0] m_mac [N];

  always @(posedge clk) begin
    pcyc = pcyc + 1;
    if (rst) begin
      q.delete();
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      if (in_vld) begin
        exp_t e;
        int best;
        best = -1;
        e.due = pcyc + 2; e.tag = cur_tag;
        e.ipv = in_ip_valid; e.dst = in_dst_ip; e.ttl = in_ttl;
        e.edst = in_eth_dst; e.esrc = in_eth_src; e.eg = in_egress;
        e.drop = in_drop; e.hit = 0;
        if (in_ip_valid) begin
          for (int i = 0; i < N; i++)
            if (m_v[i] && (((in_dst_ip ^ m_key[i]) & m_mask[i]) == 0))
              if (best < 0 || m_plen[i] > m_plen[best]) best = i;
          if (best < 0) e.drop = 1;
          else begin
            e.hit = 1;
            if (m_act[best] == 1) begin
              if (in_ttl <= 1) e.drop = 1;
              else begin
                e.eg = m_port[best]; e.esrc = in_eth_dst;
                e.edst = m_mac[best]; e.ttl = in_ttl - 8'd1;
              end
            end else if (m_act[best] >= 2) e.drop = 1;
          end
        end
        q.push_back(e);
      end
      if (cfg_we) begin
        m_v[cfg_idx] = cfg_valid; m_key[cfg_idx] = cfg_key;
        m_mask[cfg_idx] = cfg_mask; m_plen[cfg_idx] = int'(cfg_plen);
        m_act[cfg_idx] = int'(cfg_act); m_port[cfg_idx] = cfg_port;
        m_mac[cfg_idx] = cfg_mac;
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    wd = wd + 1;
    if (wd > 5000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
    if (!rst) begin
      if (out_vld) begin
        tests++;
        if (q.size() == 0 || q[0].due != pcyc) begin
          fails++;
          $display("FAIL R2 unexpected out_vld at cycle %0d: actual 1 expected 0", pcyc);
        end else begin
          exp_t e;
          e = q.pop_front();
          if ({out_hit, out_ip_valid, out_drop, out_dst_ip, out_ttl, out_eth_dst, out_eth_src, out_egress} !==
              {e.hit, e.ipv, e.drop, e.dst, e.ttl, e.edst, e.esrc, e.eg}) begin
            fails++;
            $display("FAIL %s: actual hit=%0b drop=%0b ttl=%0d eg=%0d dmac=%h smac=%h expected hit=%0b drop=%0b ttl=%0d eg=%0d dmac=%h smac=%h",
                     e.tag, out_hit, out_drop, out_ttl, out_egress, out_eth_dst, out_eth_src,
                     e.hit, e.drop, e.ttl, e.eg, e.edst, e.esrc);
          end
        end
      end else if (q.size() != 0 && q[0].due == pcyc) begin
        tests++; fails++;
        $display("FAIL R2 missing out_vld at cycle %0d (%s): actual 0 expected 1", pcyc, q[0].tag);
      end
    end
  end

  task automatic wr(input int idx, input bit v, input logic [31:0] key, input int plen,
                    input int act, input int port, input logic [47:0] mac);
    @(negedge clk);
    in_vld = 0;
    cfg_we = 1; cfg_idx = IW'(idx); cfg_valid = v; cfg_key = key;
    cfg_mask = (plen == 0) ? 32'h0 : ~(32'hFFFF_FFFF >> plen);
    cfg_plen = LW'(plen); cfg_act = 2'(act); cfg_port = PW'(port); cfg_mac = mac;
  endtask

  task automatic pkt(input string tag, input bit ipv, input logic [31:0] dst,
                     input int ttl, input bit drp);
    @(negedge clk);
    cfg_we = 0;
    cur_tag = tag;
    in_vld = 1; in_ip_valid = ipv; in_dst_ip = dst; in_ttl = 8'(ttl);
    in_eth_dst = 48'h0A0B_0C0D_0E0F; in_eth_src = 48'h1112_1314_1516;
    in_egress = PW'(33); in_drop = drp;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 0; in_vld = 0;
    end
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    // R1: outputs quiet in reset
    tests++;
    if (out_vld !== 1'b0 || out_drop !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual vld=%0b drop=%0b expected 0 0", out_vld, out_drop);
    end
    rst = 0;
    idle(2);
    pkt("R1 empty table miss", 1, 32'h0A09_0909, 64, 0);
    idle(4);

    wr(0, 1, 32'h0A00_0000, 8, 1, 3, 48'hA0A0_A0A0_A0A0);
    wr(1, 1, 32'h0A01_0000, 16, 1, 5, 48'hB1B1_B1B1_B1B1);
    wr(2, 1, 32'h0A01_0200, 24, 2, 0, 48'h0);
    wr(3, 1, 32'h0A01_0000, 16, 1, 7, 48'hC3C3_C3C3_C3C3);
    wr(4, 1, 32'hC0A8_0000, 16, 0, 0, 48'h0);
    wr(5, 1, 32'hAC10_0000, 12, 3, 0, 48'h0);
    wr(6, 1, 32'h0B00_0009, 20, 1, 9, 48'hD6D6_D6D6_D6D6);
    @(negedge clk); cfg_mask = 32'hFF00_000D;   // R3 non-contiguous mask on entry 6
    wr(15, 1, 32'h1400_0000, 8, 1, 11, 48'hEEEE_EEEE_EEEE);
    idle(1);

    // Back-to-back packets (R2)
    pkt("R6 forward /8", 1, 32'h0A09_0909, 64, 0);
    pkt("R4 tie lowest index", 1, 32'h0A01_0505, 30, 0);
    pkt("R4 longest wins, R8 drop code 2", 1, 32'h0A01_0203, 30, 0);
    pkt("R9 no-action", 1, 32'hC0A8_0101, 9, 0);
    pkt("R8 drop code 3", 1, 32'hAC14_0001, 9, 0);
    pkt("R3 masked 1001", 1, 32'h0B12_3409, 12, 0);
    pkt("R3 masked 1011", 1, 32'h0B12_340B, 12, 0);
    pkt("R3 masked miss 1101", 1, 32'h0B12_340D, 12, 0);
    pkt("R5 miss", 1, 32'h0808_0808, 50, 0);
    pkt("R10 no IPv4 bypass", 0, 32'h0A09_0909, 64, 0);
    pkt("R10 no IPv4 keeps drop", 0, 32'h0A09_0909, 64, 1);
    pkt("R7 ttl 1", 1, 32'h0A09_0909, 1, 0);
    pkt("R7 ttl 0", 1, 32'h0A09_0909, 0, 0);
    pkt("R6 ttl 2 forward", 1, 32'h0A09_0909, 2, 0);
    pkt("R12 drop in with forward", 1, 32'h0A09_0909, 64, 1);
    pkt("R11 entry 15 before remove", 1, 32'h1401_0101, 40, 0);
    wr(15, 0, 32'h1400_0000, 8, 1, 11, 48'hEEEE_EEEE_EEEE);
    pkt("R11 entry 15 removed", 1, 32'h1401_0101, 40, 0);
    wr(0, 1, 32'h0A00_0000, 8, 1, 21, 48'h1234_5678_9ABC);
    pkt("R11 overwritten entry 0", 1, 32'h0A09_0909, 64, 0);
    idle(8);

    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2 outstanding results: actual %0d expected 0", q.size());
    end
    finish_run();
  end
endmodule